// File: doc/BRIEF.md
# Infrared Serial Pulse Codec

This block sits between a UART and an infrared transceiver and translates between the UART's level-coded serial line and short-pulse infrared signalling. On the transmit side, every bit cell that carries a zero becomes a brief high pulse on the infrared output at the start of that cell. A cell that carries a one produces no light at all. On the receive side, each pulse seen on the infrared input becomes a zero level for the UART receiver, stretched to one full bit time so that the UART's mid-bit sampler sees it.

All timing comes from the UART's 16x baud clock enable. Bit rates up to 115.2 kbit/s are supported. The transmit encoder finds the start of a cell from the falling edge of the serial line, which is the start bit. After that it counts sixteen enable ticks per cell, so each pulse begins on the first tick of its cell. Frames are asynchronous: a zero start bit, then data least significant bit first, then a one stop bit.

A mode input selects infrared operation. When it is low, both directions pass straight through and the codec state is held cleared.

Top module: `irda_sir_codec`

## Requirements
- R1: While reset is applied with infrared mode on, `irtx` is low and `uart_rxd` is high.
- R2: In infrared mode, a cell whose `uart_txd` level is 0 drives `irtx` high for exactly PULSE_TICKS (3) enable ticks. The pulse is visible from the rising clock edge that samples the cell's first tick and ends at the edge of its fourth tick.
- R3: In infrared mode, a cell whose `uart_txd` level is 1, or an idle line, keeps `irtx` low for the whole cell.
- R4: A falling `uart_txd` sampled on a tick opens a cell, and further cells open every 16 ticks after it. A frame of start 0, eight data bits LSB first and stop 1 therefore gives exactly 3 pulse ticks per zero bit.
- R5: In infrared mode, a rising edge on `irrx` drives `uart_rxd` low at the third rising clock edge after the change. There is no change at the second edge.
- R6: After a pulse is detected, `uart_rxd` stays low for 16 enable ticks and returns high on the 16th tick. A new pulse restarts the 16-tick hold.
- R7: With infrared mode off, `irtx` equals `uart_txd` and `uart_rxd` equals `irrx`, both combinationally.
- R8: Turning infrared mode on after a period with it off starts with `irtx` low and `uart_rxd` high. Activity on the lines while the mode was off produces no pulse or held zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16 | input | 1 | 16x baud clock enable, one clock wide |
| ir_en | input | 1 | 1 = infrared coding, 0 = pass-through |
| uart_txd | input | 1 | Serial data from the UART transmitter |
| irtx | output | 1 | Infrared transmit drive, high = pulse |
| irrx | input | 1 | Infrared receive, high = pulse detected |
| uart_rxd | output | 1 | Serial data to the UART receiver |

## Verification
Transmit results are due at the clock edge that samples a tick. The bench therefore checks `irtx` at the falling clock edge right after each tick, against the bit level and the tick's position in its cell. The receive path has two registers of synchronization and one edge register, so `uart_rxd` is checked at the falling edges after the second and third rising edges following an `irrx` change. The hold is then checked after the 15th and 16th ticks. Pass-through is combinational and is checked a short delay after each input change, with no clock edge in between.

// File: rtl/irda_sir_pkg.sv
package irda_sir_pkg;
  localparam int unsigned DEF_OVERSAMPLE  = 16;
  localparam int unsigned DEF_PULSE_TICKS = 3;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_RST_STAGES  = 2;
endpackage

// File: rtl/irda_rst_sync.sv
module irda_rst_sync #(
  parameter int unsigned STAGES = irda_sir_pkg::DEF_RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irda_sir_enc.sv
module irda_sir_enc #(
  parameter int unsigned OVERSAMPLE  = irda_sir_pkg::DEF_OVERSAMPLE,
  parameter int unsigned PULSE_TICKS = irda_sir_pkg::DEF_PULSE_TICKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic txd,
  output logic pulse
);
  localparam int unsigned PH_W  = $clog2(OVERSAMPLE);
  localparam int unsigned CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_TICKS);

  logic [PH_W-1:0]  phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_q, last_d;
  logic             cell_start;

  // A cell opens on the start-bit edge or after a full cell of ticks
  always_comb begin
    cell_start = tick && ((last_q && !txd) || (phase_q == PH_LAST));
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    last_d     = last_q;
    if (!en) begin
      phase_d = '0;
      cnt_d   = '0;
      last_d  = 1'b1;
    end else if (tick) begin
      last_d = txd;
      if (cell_start) begin
        phase_d = '0;
        cnt_d   = txd ? '0 : CNT_LOAD;
      end else begin
        phase_d = phase_q + 1'b1;
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      cnt_q   <= '0;
      last_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
    end
  end

  assign pulse = (cnt_q != '0);

  assert_zero_pulse_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (en && cell_start && !txd) |=> (cnt_q == CNT_LOAD && pulse));

  assert_one_dark_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (en && cell_start && txd) |=> !pulse);

  assert_tick_paced_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> ($stable(phase_q) && $stable(cnt_q)));

  assert_off_cleared_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pulse && last_q));
endmodule

// File: rtl/irda_sir_dec.sv
module irda_sir_dec #(
  parameter int unsigned OVERSAMPLE  = irda_sir_pkg::DEF_OVERSAMPLE,
  parameter int unsigned SYNC_STAGES = irda_sir_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic irrx,
  output logic rxd
);
  localparam int unsigned HOLD_W = $clog2(OVERSAMPLE + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(OVERSAMPLE);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [HOLD_W-1:0]      hold_q, hold_d;
  logic                   seen;
  logic                   rise;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= irrx;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], irrx};
      end
    end
  endgenerate

  assign seen = sync_q[SYNC_STAGES-1];
  assign rise = seen && !prev_q;

  always_comb begin
    hold_d = hold_q;
    if (!en)                           hold_d = '0;
    else if (rise)                     hold_d = HOLD_LOAD;
    else if (tick && (hold_q != '0))   hold_d = hold_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= '0;
    end else begin
      prev_q <= seen;
      hold_q <= hold_d;
    end
  end

  assign rxd = (hold_q == '0);

  assert_rise_low_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (en && rise) |=> !rxd);

  assert_hold_paced_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (en && !rise && !tick) |=> $stable(hold_q));

  assert_off_idle_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> rxd);
endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec #(
  parameter int unsigned OVERSAMPLE  = irda_sir_pkg::DEF_OVERSAMPLE,
  parameter int unsigned PULSE_TICKS = irda_sir_pkg::DEF_PULSE_TICKS,
  parameter int unsigned SYNC_STAGES = irda_sir_pkg::DEF_SYNC_STAGES,
  parameter int unsigned RST_STAGES  = irda_sir_pkg::DEF_RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic ir_en,
  input  logic uart_txd,
  output logic irtx,
  input  logic irrx,
  output logic uart_rxd
);
  logic rst_int_n;
  logic enc_pulse;
  logic dec_rxd;

  irda_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irda_sir_enc #(.OVERSAMPLE(OVERSAMPLE), .PULSE_TICKS(PULSE_TICKS)) i_enc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (ir_en),
    .tick  (tick16),
    .txd   (uart_txd),
    .pulse (enc_pulse)
  );

  irda_sir_dec #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)) i_dec (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (ir_en),
    .tick  (tick16),
    .irrx  (irrx),
    .rxd   (dec_rxd)
  );

  assign irtx     = ir_en ? enc_pulse : uart_txd;
  assign uart_rxd = ir_en ? dec_rxd   : irrx;

  assert_reset_quiet_R1 : assert property (@(posedge clk)
    (!rst_int_n && ir_en) |-> (!irtx && uart_rxd));
endmodule

// File: tb/test_irda_sir_codec.sv
module test_irda_sir_codec;
  localparam int OVS   = 16;
  localparam int PULSE = 3;
  localparam int TDIV  = 3;

  logic clk = 1'b0;
  logic rst_n, tick16, ir_en, uart_txd, irrx;
  logic irtx, uart_rxd;
  int   n_checks = 0;
  int   n_errors = 0;
  int   cyc = 0;
  int   pulse_seen;

  always #2 clk = ~clk;

  irda_sir_codec i_irda_sir_codec (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .ir_en(ir_en),
    .uart_txd(uart_txd), .irtx(irtx), .irrx(irrx), .uart_rxd(uart_rxd)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog (all requirements): cycles=%0d expected < %0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  function automatic logic exp_tx(input logic b, input int pos);
    return (b == 1'b0) && (pos < PULSE);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) tick16 = 1'b1;
    @(negedge clk) tick16 = 1'b0;
    repeat (TDIV - 1) @(negedge clk);
  endtask

  task automatic send_cell(input logic b);
    uart_txd = b;
    for (int j = 0; j < OVS; j++) begin
      tick_once();
      if (irtx) pulse_seen++;
      if (b) check("R3 one cell dark", irtx, exp_tx(b, j));
      else   check("R2 zero cell pulse", irtx, exp_tx(b, j));
    end
  endtask

  task automatic send_frame(input logic [7:0] d);
    int zeros;
    zeros = 1;
    pulse_seen = 0;
    send_cell(1'b0);
    for (int i = 0; i < 8; i++) begin
      send_cell(d[i]);
      if (!d[i]) zeros++;
    end
    send_cell(1'b1);
    check_int("R4 frame pulse ticks", pulse_seen, zeros * PULSE);
  endtask

  task automatic idle_ticks(input int n);
    uart_txd = 1'b1;
    for (int j = 0; j < n; j++) begin
      tick_once();
      check("R3 idle dark", irtx, 1'b0);
    end
  endtask

  task automatic rx_cell(input logic b);
    if (!b) irrx = 1'b1;
    repeat (3) @(negedge clk);
    if (!b) check("R5 pulse to low", uart_rxd, 1'b0);
    for (int j = 0; j < OVS; j++) begin
      tick_once();
      if (j == 2) irrx = 1'b0;
      if (j == 7) check("R6 mid-cell level", uart_rxd, b);
    end
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1bad5eed));
    rst_n = 1'b0; tick16 = 1'b0; ir_en = 1'b1; uart_txd = 1'b1; irrx = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset irtx", irtx, 1'b0);
    check("R1 reset rxd", uart_rxd, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // transmit: directed corners then random frames with random idle gaps
    idle_ticks(5);
    send_frame(8'h00);
    send_frame(8'hFF);
    send_frame(8'h55);
    for (int k = 0; k < 8; k++) begin
      idle_ticks($urandom_range(0, 37));
      d = 8'($urandom);
      send_frame(d);
    end
    idle_ticks(20);

    // receive latency
    irrx = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R5 no change at second edge", uart_rxd, 1'b1);
    @(negedge clk);
    check("R5 low at third edge", uart_rxd, 1'b0);
    for (int j = 1; j <= OVS; j++) begin
      tick_once();
      if (j == 2) irrx = 1'b0;
      if (j == OVS - 1) check("R6 still low after 15 ticks", uart_rxd, 1'b0);
      if (j == OVS)     check("R6 high after 16 ticks", uart_rxd, 1'b1);
    end

    // retrigger
    irrx = 1'b1;
    repeat (3) @(negedge clk);
    tick_once(); tick_once();
    irrx = 1'b0;
    repeat (8) tick_once();
    irrx = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 retrigger low", uart_rxd, 1'b0);
    irrx = 1'b0;
    repeat (OVS - 1) tick_once();
    check("R6 retrigger holds 15", uart_rxd, 1'b0);
    tick_once();
    check("R6 retrigger ends 16", uart_rxd, 1'b1);

    // receive random cells
    for (int k = 0; k < 24; k++) rx_cell(1'($urandom));
    repeat (OVS) tick_once();

    // pass-through
    ir_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      uart_txd = 1'($urandom);
      irrx     = 1'($urandom);
      #1;
      check("R7 tx pass", irtx, uart_txd);
      check("R7 rx pass", uart_rxd, irrx);
    end
    uart_txd = 1'b0; irrx = 1'b1;
    repeat (20) tick_once();
    check("R7 tx pass held low", irtx, 1'b0);
    uart_txd = 1'b1; irrx = 1'b0;
    repeat (5) @(negedge clk);
    ir_en = 1'b1;
    #1;
    check("R8 re-enable irtx", irtx, 1'b0);
    check("R8 re-enable rxd", uart_rxd, 1'b1);
    for (int j = 0; j < 20; j++) begin
      tick_once();
      check("R8 stays quiet tx", irtx, 1'b0);
      check("R8 stays quiet rx", uart_rxd, 1'b1);
    end
    send_frame(8'hA3);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule